// File: doc/BRIEF.md
# Vector Mask Test and Merge Unit

This unit keeps a mask with one bit per vector element and does two things with it. A test operation streams in the elements of one vector operand, one element per cycle, and sets a mask bit for each element that meets the selected condition. There are four conditions: the element is zero, it is nonzero, its sign bit is clear, or its sign bit is set. A merge operation streams in element pairs and, for each element, returns either a broadcast scalar or an element of one vector source when that element's mask bit is set, and an element of the other vector source when it is clear. The mask can also be loaded directly from a scalar operand, and it can be read at any time on a dedicated port.

An operation starts with a one-cycle `op_start` pulse while the unit is idle. Test and merge operations then accept one element on each cycle where `elem_valid` is high. A stall is simply a cycle with `elem_valid` low. The number of elements comes from a length register set by its own operation. A stored length of zero means a full vector. Mask bit `MAX_LEN-1` belongs to element 0, so the mask can be read out as a scalar with element 0 at the most significant end.

Top module: `vmask_merge_unit`

## Requirements
- R1: After reset, `mask_out` is zero, `vlen_out` is zero, and `busy`, `done` and `res_valid` are all low.
- R2: Opcode 0 (test zero) commits a mask in which bit 63-i is 1 exactly when element i on `elem_b` equals zero.
- R3: Opcode 1 (test nonzero) commits a mask in which bit 63-i is 1 exactly when element i on `elem_b` is not zero.
- R4: Opcode 2 (test sign clear) commits a mask in which bit 63-i is 1 exactly when bit 63 of element i on `elem_b` is 0.
- R5: Opcode 3 (test sign set) commits a mask in which bit 63-i is 1 exactly when bit 63 of element i on `elem_b` is 1.
- R6: A test operation processes the number of elements given by the length register, or 64 when that register holds 0. Every mask bit for an element at or beyond that count is 0 in the committed mask.
- R7: While a test is running, `mask_out` keeps its old value. The new mask appears, and `done` is high for exactly one cycle, in the cycle after the last element is accepted.
- R8: Opcode 4 (load mask) sets `mask_out` to `scalar_in` in the cycle after the start.
- R9: Opcode 5 (merge scalar) outputs, for element i, the `scalar_in` value captured at the start when mask bit 63-i is 1, and `elem_b` when it is 0.
- R10: Opcode 6 (merge vector) outputs, for element i, `elem_a` when mask bit 63-i is 1, and `elem_b` when it is 0.
- R11: Opcode 7 (set length) stores `scalar_in` modulo 64 (its low 6 bits) and shows it on `vlen_out` in the next cycle.
- R12: A start pulse that arrives while `busy` is high is ignored. It does not change the length, the mask or the running operation.
- R13: During a merge, `res_valid` is high in the cycle after each accepted element and at no other time. Exactly one result is produced per processed element, in element order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Starts the operation on `op_code` when idle |
| op_code | input | 3 | Operation: 0 zero, 1 nonzero, 2 sign clear, 3 sign set, 4 load mask, 5 merge scalar, 6 merge vector, 7 set length |
| scalar_in | input | ELEM_W | Scalar for broadcast, mask load or length |
| elem_valid | input | 1 | An element is present on `elem_a`/`elem_b` |
| elem_a | input | ELEM_W | Element of the vector selected where the mask bit is set (merge vector) |
| elem_b | input | ELEM_W | Element tested, or selected where the mask bit is clear |
| busy | output | 1 | A test or merge is in progress |
| done | output | 1 | One-cycle pulse after the last element |
| res_valid | output | 1 | `res_data` holds a merge result |
| res_data | output | ELEM_W | Merge result element |
| mask_out | output | MAX_LEN | Current mask, bit MAX_LEN-1 is element 0 |
| vlen_out | output | LEN_W | Stored vector length |

## Verification
The assertions check four rules on every cycle. The mask never changes during a running operation except at its completion. A direct mask load and a length write land exactly one cycle after the start. The length stays fixed while the unit is busy. Every result and every done pulse follows an accepted element. The bench's scenarios are needed for the rest: the value of each mask bit under the four test conditions, the clearing of bits past the length, the 64-element meaning of length zero, and the per-element choice of source in both merge modes. These are checked against reference functions, using random vectors and directed lengths of 1, 6, 63 and 64.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

   typedef enum logic [2:0] {
      VM_TST_ZERO = 3'd0,
      VM_TST_NZ   = 3'd1,
      VM_TST_POS  = 3'd2,
      VM_TST_NEG  = 3'd3,
      VM_LOAD     = 3'd4,
      VM_MRG_SCAL = 3'd5,
      VM_MRG_VEC  = 3'd6,
      VM_SET_LEN  = 3'd7
   } vm_op_e;

   function automatic logic vm_is_stream(input vm_op_e op);
      return (op != VM_LOAD) && (op != VM_SET_LEN);
   endfunction

   function automatic logic vm_is_test(input vm_op_e op);
      return ~op[2];
   endfunction

endpackage

// File: rtl/vmm_elem_test.sv
module vmm_elem_test #(
   parameter int ELEM_W = 64
) (
   input  logic [1:0]        mode,
   input  logic [ELEM_W-1:0] elem,
   output logic              hit
);
   logic is_zero;
   logic is_neg;

   assign is_zero = ~|elem;
   assign is_neg  = elem[ELEM_W-1];

   always_comb begin
      unique case (mode)
         2'd0:    hit = is_zero;
         2'd1:    hit = ~is_zero;
         2'd2:    hit = ~is_neg;
         default: hit = is_neg;
      endcase
   end
endmodule

// File: rtl/vmm_seq.sv
module vmm_seq #(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             elem_valid,
   input  logic [LEN_W-1:0] vlen,
   output logic             busy,
   output logic             fire,
   output logic             last,
   output logic [LEN_W-1:0] idx
);
   logic [LEN_W-1:0] last_idx;

   assign last_idx = (vlen == '0) ? LEN_W'(MAX_LEN - 1) : vlen - 1'b1;
   assign fire     = busy & elem_valid;
   assign last     = fire & (idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (fire) begin
         idx <= idx + 1'b1;
         if (last) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/vmm_mask_reg.sv
module vmm_mask_reg #(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_shadow,
   input  logic               wr_bit,
   input  logic [LEN_W-1:0]   idx,
   input  logic               hit,
   input  logic               commit,
   input  logic               load,
   input  logic [MAX_LEN-1:0] load_val,
   output logic [MAX_LEN-1:0] mask
);
   logic [MAX_LEN-1:0] shadow;
   logic [MAX_LEN-1:0] sel;
   logic [MAX_LEN-1:0] final_val;

   for (genvar g = 0; g < MAX_LEN; g++) begin : g_bit
      assign sel[g]       = (idx == LEN_W'(MAX_LEN - 1 - g));
      assign final_val[g] = sel[g] ? hit : shadow[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                shadow[g] <= 1'b0;
         else if (clr_shadow)       shadow[g] <= 1'b0;
         else if (wr_bit && sel[g]) shadow[g] <= hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask <= '0;
      else if (load)   mask <= load_val;
      else if (commit) mask <= final_val;
   end
endmodule

// File: rtl/vmm_merge_out.sv
module vmm_merge_out #(
   parameter int ELEM_W  = 64,
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic               sel_scalar,
   input  logic [ELEM_W-1:0]  scalar,
   input  logic [ELEM_W-1:0]  a,
   input  logic [ELEM_W-1:0]  b,
   input  logic [MAX_LEN-1:0] mask,
   input  logic [LEN_W-1:0]   idx,
   output logic               res_valid,
   output logic [ELEM_W-1:0]  res_data
);
   logic              mbit;
   logic [ELEM_W-1:0] chosen;

   assign mbit   = mask[LEN_W'(MAX_LEN - 1) - idx];
   assign chosen = mbit ? (sel_scalar ? scalar : a) : b;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
         end else begin
            res_valid <= fire;
            if (fire) res_data <= chosen;
         end
      end
   end else begin : g_comb
      assign res_valid = fire;
      assign res_data  = chosen;
   end
endmodule

// File: rtl/vmask_merge_unit.sv
module vmask_merge_unit
   import vmm_pkg::*;
#(
   parameter int ELEM_W  = 64,
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = $clog2(MAX_LEN),
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_start,
   input  logic [2:0]         op_code,
   input  logic [ELEM_W-1:0]  scalar_in,
   input  logic               elem_valid,
   input  logic [ELEM_W-1:0]  elem_a,
   input  logic [ELEM_W-1:0]  elem_b,
   output logic               busy,
   output logic               done,
   output logic               res_valid,
   output logic [ELEM_W-1:0]  res_data,
   output logic [MAX_LEN-1:0] mask_out,
   output logic [LEN_W-1:0]   vlen_out
);
   if ((1 << LEN_W) != MAX_LEN || MAX_LEN < 2) begin : g_bad_len
      $error("MAX_LEN must be a power of two equal to 2**LEN_W");
   end
   if (ELEM_W < MAX_LEN) begin : g_bad_width
      $error("ELEM_W must be at least MAX_LEN so the mask fits a scalar");
   end

   vm_op_e            op_in;
   vm_op_e            op_q;
   logic [ELEM_W-1:0] scal_q;
   logic [LEN_W-1:0]  vlen_q;
   logic              accept;
   logic              launch;
   logic              fire;
   logic              last;
   logic [LEN_W-1:0]  idx;
   logic              hit;
   logic              test_op;

   assign op_in   = vm_op_e'(op_code);
   assign accept  = op_start & ~busy;
   assign launch  = accept & vm_is_stream(op_in);
   assign test_op = vm_is_test(op_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= VM_TST_ZERO;
         scal_q <= '0;
         vlen_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= last;
         if (launch) begin
            op_q   <= op_in;
            scal_q <= scalar_in;
         end
         if (accept && op_in == VM_SET_LEN) vlen_q <= scalar_in[LEN_W-1:0];
      end
   end

   assign vlen_out = vlen_q;

   vmm_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .elem_valid(elem_valid),
      .vlen(vlen_q), .busy(busy), .fire(fire), .last(last), .idx(idx)
   );

   vmm_elem_test #(.ELEM_W(ELEM_W)) i_test (
      .mode(op_q[1:0]), .elem(elem_b), .hit(hit)
   );

   vmm_mask_reg #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_mask (
      .clk(clk), .rst_n(rst_n), .clr_shadow(launch), .wr_bit(fire & test_op),
      .idx(idx), .hit(hit), .commit(last & test_op),
      .load(accept && op_in == VM_LOAD), .load_val(scalar_in[MAX_LEN-1:0]),
      .mask(mask_out)
   );

   vmm_merge_out #(.ELEM_W(ELEM_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .OUT_REG(OUT_REG)) i_merge (
      .clk(clk), .rst_n(rst_n), .fire(fire & ~test_op),
      .sel_scalar(op_q == VM_MRG_SCAL), .scalar(scal_q), .a(elem_a), .b(elem_b),
      .mask(mask_out), .idx(idx), .res_valid(res_valid), .res_data(res_data)
   );
endmodule

// File: rtl/vmm_checker.sv
module vmm_checker #(
   parameter int ELEM_W  = 64,
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               op_start,
   input logic [2:0]         op_code,
   input logic [ELEM_W-1:0]  scalar_in,
   input logic               elem_valid,
   input logic               busy,
   input logic               done,
   input logic               res_valid,
   input logic [MAX_LEN-1:0] mask_out,
   input logic [LEN_W-1:0]   vlen_out
);
   // R7: during an operation the mask only moves together with done
   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(mask_out) || done));

   // R7: done is a single-cycle pulse that follows a busy cycle
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R8: direct mask load
   assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !busy && op_code == 3'd4) |=> (mask_out == $past(scalar_in[MAX_LEN-1:0])));

   // R11: length write keeps the low bits of the scalar
   assert_len_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start && !busy && op_code == 3'd7) |=> (vlen_out == $past(scalar_in[LEN_W-1:0])));

   // R12: length cannot change while busy
   assert_len_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vlen_out));

   // R13: a result only follows an accepted element
   assert_res_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(busy && elem_valid));
endmodule

bind vmask_merge_unit vmm_checker #(.ELEM_W(ELEM_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) i_vmm_checker (
   .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
   .scalar_in(scalar_in), .elem_valid(elem_valid), .busy(busy), .done(done),
   .res_valid(res_valid), .mask_out(mask_out), .vlen_out(vlen_out)
);

// File: tb/test_vmask_merge_unit.sv
module test_vmask_merge_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_start = 1'b0;
   logic [2:0]  op_code = '0;
   logic [63:0] scalar_in = '0;
   logic        elem_valid = 1'b0;
   logic [63:0] elem_a = '0;
   logic [63:0] elem_b = '0;
   logic        busy, done, res_valid;
   logic [63:0] res_data;
   logic [63:0] mask_out;
   logic [5:0]  vlen_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [63:0] va [64];
   logic [63:0] vb [64];
   logic [63:0] m_mask = '0;
   logic [5:0]  m_len = '0;

   always #4 clk = ~clk;

   vmask_merge_unit i_vmask_merge_unit (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
      .scalar_in(scalar_in), .elem_valid(elem_valid), .elem_a(elem_a), .elem_b(elem_b),
      .busy(busy), .done(done), .res_valid(res_valid), .res_data(res_data),
      .mask_out(mask_out), .vlen_out(vlen_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int eff_len(input logic [5:0] l);
      return (l == 6'd0) ? 64 : int'(l);
   endfunction

   function automatic logic ref_hit(input int mode, input logic [63:0] e);
      case (mode)
         0:       return e == 64'd0;
         1:       return e != 64'd0;
         2:       return !e[63];
         default: return e[63];
      endcase
   endfunction

   function automatic logic [63:0] rand_elem();
      int r = $urandom % 4;
      if (r == 0) return 64'd0;
      if (r == 1) return {1'b1, 31'($urandom), 32'($urandom)};
      return {32'($urandom), 32'($urandom)};
   endfunction

   task automatic fill_vectors();
      for (int i = 0; i < 64; i++) begin
         va[i] = rand_elem();
         vb[i] = rand_elem();
      end
   endtask

   task automatic simple_op(input logic [2:0] code, input logic [63:0] sc);
      @(negedge clk);
      op_start = 1'b1; op_code = code; scalar_in = sc;
      @(negedge clk);
      op_start = 1'b0;
      if (code == 3'd7) begin
         m_len = sc[5:0];
         chk("R11 length write", 64'(vlen_out), 64'(m_len));
      end else begin
         m_mask = sc;
         chk("R8 mask load", mask_out, m_mask);
      end
   endtask

   // test ops 0..3 and merge ops 5/6; optional start injected while busy
   task automatic run_op(input int code, input logic [63:0] sc, input bit inject);
      int n = eff_len(m_len);
      logic [63:0] exp_mask = '0;
      logic [63:0] exp_res;
      string rq;
      rq = (code == 0) ? "R2" : (code == 1) ? "R3" : (code == 2) ? "R4" :
           (code == 3) ? "R5" : (code == 5) ? "R9" : "R10";
      @(negedge clk);
      op_start = 1'b1; op_code = 3'(code); scalar_in = sc;
      @(negedge clk);
      op_start = 1'b0;
      chk("R7 busy after start", 64'(busy), 64'd1);
      for (int i = 0; i < n; i++) begin
         if (i == 2) begin
            elem_valid = 1'b0;
            @(negedge clk);
            chk("R13 no result on stall", 64'(res_valid), 64'd0);
         end
         elem_valid = 1'b1; elem_a = va[i]; elem_b = vb[i];
         op_start = inject && (i == 1);
         op_code = 3'd7; scalar_in = 64'd3;
         if (code < 4 && ref_hit(code, vb[i])) exp_mask[63 - i] = 1'b1;
         @(negedge clk);
         op_start = 1'b0;
         if (code >= 4) begin
            exp_res = m_mask[63 - i] ? ((code == 5) ? sc : va[i]) : vb[i];
            chk("R13 result valid", 64'(res_valid), 64'd1);
            chk({rq, " merge element"}, res_data, exp_res);
         end else if (i < n - 1) begin
            chk("R7 mask held mid-test", mask_out, m_mask);
            chk("R7 no early done", 64'(done), 64'd0);
         end
         if (i == n - 1) begin
            chk("R7 done pulse", 64'(done), 64'd1);
            if (code < 4) begin
               m_mask = exp_mask;
               chk({rq, " R6 committed mask"}, mask_out, exp_mask);
            end
         end
      end
      elem_valid = 1'b0;
      @(negedge clk);
      chk("R7 done falls", 64'(done), 64'd0);
      chk("R13 no extra result", 64'(res_valid), 64'd0);
      chk("R6 idle after length", 64'(busy), 64'd0);
      if (inject) begin
         chk("R12 length kept", 64'(vlen_out), 64'(m_len));
         chk("R12 mask kept", mask_out, m_mask);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 mask reset", mask_out, 64'd0);
      chk("R1 length reset", 64'(vlen_out), 64'd0);
      chk("R1 busy reset", 64'(busy), 64'd0);
      chk("R1 done reset", 64'(done), 64'd0);
      chk("R1 result reset", 64'(res_valid), 64'd0);
      rst_n = 1'b1;

      // length zero means 64 elements
      simple_op(3'd7, 64'd0);
      for (int m = 0; m < 4; m++) begin
         fill_vectors();
         run_op(m, 64'd0, 1'b0);
      end
      // length is taken modulo 64; stale mask bits beyond it are cleared
      simple_op(3'd7, 64'd70);
      simple_op(3'd4, '1);
      fill_vectors();
      run_op(0, 64'd0, 1'b0);
      simple_op(3'd7, 64'd1);
      fill_vectors();
      vb[0] = 64'h8000_0000_0000_0001;
      run_op(3, 64'd0, 1'b0);
      simple_op(3'd7, 64'd63);
      fill_vectors();
      run_op(1, 64'd0, 1'b0);
      // merges under a loaded mask, with a start injected while busy
      simple_op(3'd4, {32'($urandom), 32'($urandom)});
      simple_op(3'd7, 64'd10);
      fill_vectors();
      run_op(5, 64'hDEAD_BEEF_0123_4567, 1'b1);
      fill_vectors();
      run_op(6, 64'd0, 1'b1);
      // random mix
      for (int k = 0; k < 12; k++) begin
         int c = $urandom % 7;
         simple_op(3'd7, 64'($urandom % 64));
         if (c == 4) simple_op(3'd4, {32'($urandom), 32'($urandom)});
         else begin
            fill_vectors();
            run_op(c, {32'($urandom), 32'($urandom)}, 1'($urandom % 2));
         end
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule